// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Pin Overrides

This block controls an 8-pin general-purpose I/O port sitting on a simple register bus. Software sets an output/pull-up latch and a per-pin direction mask, and can read back either register or the synchronized logic levels seen on the pads. For each pin the block drives three pad-control lines: an output enable, an output value and a pull-up enable. The analog pad itself stays outside.

Several on-chip peripherals share the pins. An SPI unit can run as master or slave, a UART has separate transmit and receive enables, and two timer compare channels exist. Each of these can force a pin to be an input, force it to be an output, or replace the latch bit as the driven value. When a peripheral forces a pin to be an input, the latch bit still controls that pin's pull-up. When an override is released, the pin goes straight back to register control, and the register contents are unchanged.

Top module: `gpio_port_ovr`

## Requirements
- R1: While `rst_n` is low, the latch and direction registers read 0, and `pad_oe` and `pad_pu` are all zero. This takes effect asynchronously, with no clock edge needed.
- R2: A bus write at address 0x18 loads the latch register. A read at 0x18 returns the latch contents.
- R3: A bus write at address 0x17 loads the direction register, and a read at 0x17 returns it. A write at the pin address 0x16 changes neither register.
- R4: A pin with no override and direction bit 1 has `pad_oe`=1, `pad_out` equal to its latch bit, and `pad_pu`=0.
- R5: A pin with no override and direction bit 0 has `pad_oe`=0 and `pad_out`=0, and `pad_pu` equals its latch bit.
- R6: A read at 0x16 returns the `pad_in` value that was sampled two rising clock edges earlier.
- R7: With `spi_en`=1 and `spi_master`=0 (slave), pins 7, 5 and 4 are inputs whatever their direction bits are. Their pull-ups follow their latch bits.
- R8: In SPI slave mode, pin 6 follows its direction bit. When it is driven, the pin carries `spi_miso_o`.
- R9: In SPI master mode, pin 6 is an input, and its pull-up follows latch bit 6. Pins 7 and 5 follow their direction bits and, when driven, carry `spi_sck_o` and `spi_mosi_o`. Pin 4 stays under register control.
- R10: With `uart_tx_en`=1, pin 3 is an output carrying `uart_tx_d` whatever direction bit 3 is.
- R11: With `uart_rx_en`=1, pin 2 is an input whatever direction bit 2 is, and its pull-up follows latch bit 2.
- R12: With `tmr_oc_en[k]`=1, pin k (k = 0 or 1) carries `tmr_oc[k]` only when direction bit k is 1. Otherwise the pin behaves as a plain input.
- R13: Releasing every override returns all pins to the R4/R5 behaviour in the same cycle, and the latch and direction registers read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Levels seen at the pads |
| spi_en | input | 1 | SPI unit enabled |
| spi_master | input | 1 | SPI mode: 1 master, 0 slave |
| spi_sck_o | input | 1 | SPI clock value when master |
| spi_mosi_o | input | 1 | SPI data out when master |
| spi_miso_o | input | 1 | SPI data out when slave |
| uart_tx_en | input | 1 | UART transmitter enabled |
| uart_tx_d | input | 1 | UART transmit data |
| uart_rx_en | input | 1 | UART receiver enabled |
| tmr_oc_en | input | 2 | Timer compare output enables, one bit per pin 0 and 1 |
| tmr_oc | input | 2 | Timer compare output values |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value, 0 when not enabled |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
A corrupted latch or direction bit shows up at the pads within the same cycle: the pin's `pad_oe`, `pad_out` or `pad_pu` no longer matches the register it reads back. A wrong override decode shows up only while the matching peripheral enable is set, so each SPI mode, each UART enable and each timer channel is exercised with the direction and latch bits both set and cleared. A broken synchronizer shifts the pin readback by a cycle. Comparing against the reference on every clock exposes that on the first `pad_in` change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int PIN_SCK  = 7;
  localparam int PIN_MISO = 6;
  localparam int PIN_MOSI = 5;
  localparam int PIN_SSEL = 4;
  localparam int PIN_TXD  = 3;
  localparam int PIN_RXD  = 2;
  localparam int PIN_OC1  = 1;
  localparam int PIN_OC0  = 0;

  typedef struct packed {
    logic       spi_slave;
    logic       spi_master;
    logic       sck;
    logic       mosi;
    logic       miso;
    logic       tx_en;
    logic       tx_d;
    logic       rx_en;
    logic [1:0] oc_en;
    logic [1:0] oc;
  } periph_t;

  typedef struct packed {
    logic force_in;
    logic force_out;
    logic use_alt;
    logic alt;
  } ovr_t;

  // Override request for one pin, from the peripheral state.
  function automatic ovr_t pin_override(int idx, periph_t p);
    ovr_t o;
    o = '0;
    case (idx)
      PIN_SCK:  begin o.force_in = p.spi_slave;  o.use_alt = p.spi_master; o.alt = p.sck;  end
      PIN_MOSI: begin o.force_in = p.spi_slave;  o.use_alt = p.spi_master; o.alt = p.mosi; end
      PIN_SSEL: begin o.force_in = p.spi_slave;  end
      PIN_MISO: begin o.force_in = p.spi_master; o.use_alt = p.spi_slave;  o.alt = p.miso; end
      PIN_TXD:  begin o.force_out = p.tx_en; o.use_alt = p.tx_en; o.alt = p.tx_d; end
      PIN_RXD:  begin o.force_in = p.rx_en; end
      PIN_OC1:  begin o.use_alt = p.oc_en[1]; o.alt = p.oc[1]; end
      PIN_OC0:  begin o.use_alt = p.oc_en[0]; o.alt = p.oc[0]; end
      default:  o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic         up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      up_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
      up_q <= 1'b1;
    end
  end

  assign q = s2_q;

  // R6: each stage takes the previous edge's value of the one before it
  a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    s1_q == $past(d));
  a_r6_second_stage: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    s2_q == $past(s1_q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int             W  = 8,
  parameter int             AW = 6,
  parameter logic [AW-1:0]  OFS_LATCH = 'h18,
  parameter logic [AW-1:0]  OFS_DIR   = 'h17,
  parameter logic [AW-1:0]  OFS_PIN   = 'h16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_val,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  rdata
);
  logic wr_latch, wr_dir, wr_pin;

  assign wr_latch = wr && (addr == OFS_LATCH);
  assign wr_dir   = wr && (addr == OFS_DIR);
  assign wr_pin   = wr && (addr == OFS_PIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_LATCH)    rdata = latch_q;
    else if (addr == OFS_DIR) rdata = dir_q;
    else if (addr == OFS_PIN) rdata = pin_val;
  end

  // R2
  a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> latch_q == $past(wdata));
  // R3
  a_r3_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  a_r3_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin |=> $stable(latch_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] dir,
  input  periph_t      p,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic [W-1:0] pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    ovr_t o;
    logic drive;
    logic val;
    assign o     = pin_override(i, p);
    assign drive = o.force_out | (dir[i] & ~o.force_in);
    assign val   = o.use_alt ? o.alt : latch[i];
    assign oe[i]  = rst_n & drive;
    assign out[i] = rst_n & drive & val;
    assign pu[i]  = rst_n & ~drive & latch[i];
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int            W  = 8,
  parameter int            AW = 6,
  parameter logic [AW-1:0] OFS_LATCH = 'h18,
  parameter logic [AW-1:0] OFS_DIR   = 'h17,
  parameter logic [AW-1:0] OFS_PIN   = 'h16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  input  logic          spi_en,
  input  logic          spi_master,
  input  logic          spi_sck_o,
  input  logic          spi_mosi_o,
  input  logic          spi_miso_o,
  input  logic          uart_tx_en,
  input  logic          uart_tx_d,
  input  logic          uart_rx_en,
  input  logic [1:0]    tmr_oc_en,
  input  logic [1:0]    tmr_oc,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);
  logic [W-1:0] latch_q, dir_q, pin_sync;
  logic         spi_slave_w, spi_master_w;
  periph_t      per;

  assign spi_slave_w  = spi_en & ~spi_master;
  assign spi_master_w = spi_en &  spi_master;

  always_comb begin
    per            = '0;
    per.spi_slave  = spi_slave_w;
    per.spi_master = spi_master_w;
    per.sck        = spi_sck_o;
    per.mosi       = spi_mosi_o;
    per.miso       = spi_miso_o;
    per.tx_en      = uart_tx_en;
    per.tx_d       = uart_tx_d;
    per.rx_en      = uart_rx_en;
    per.oc_en      = tmr_oc_en;
    per.oc         = tmr_oc;
  end

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.W(W), .AW(AW), .OFS_LATCH(OFS_LATCH), .OFS_DIR(OFS_DIR),
              .OFS_PIN(OFS_PIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .pin_val(pin_sync), .latch_q(latch_q), .dir_q(dir_q), .rdata(bus_rdata)
  );

  gpio_pad_ctl #(.W(W)) u_pad (
    .rst_n(rst_n), .latch(latch_q), .dir(dir_q), .p(per),
    .oe(pad_oe), .out(pad_out), .pu(pad_pu)
  );

  // R1: pads quiet while reset is held
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (pad_oe == '0 && pad_pu == '0);
  end

  // R7
  a_r7_slave_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_slave_w |-> !pad_oe[PIN_SCK] && !pad_oe[PIN_MOSI] && !pad_oe[PIN_SSEL]
                    && pad_pu[PIN_SSEL] == latch_q[PIN_SSEL]);
  // R9
  a_r9_master_miso_in: assert property (@(posedge clk) disable iff (!rst_n)
    spi_master_w |-> !pad_oe[PIN_MISO] && pad_pu[PIN_MISO] == latch_q[PIN_MISO]);
  // R10
  a_r10_tx_drives: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tx_en |-> pad_oe[PIN_TXD] && pad_out[PIN_TXD] == uart_tx_d && !pad_pu[PIN_TXD]);
  // R11
  a_r11_rx_input: assert property (@(posedge clk) disable iff (!rst_n)
    uart_rx_en |-> !pad_oe[PIN_RXD] && pad_pu[PIN_RXD] == latch_q[PIN_RXD]);
  // R12
  a_r12_timer_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_oc_en[0] && !dir_q[PIN_OC0]) |-> !pad_oe[PIN_OC0]);
  // R4/R5: output enable and pull-up never on together
  a_r5_pu_off_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);
endmodule

// File: tb/sim_gpio_port_ovr.sv
`timescale 1ns/1ps
module sim_gpio_port_ovr;
  localparam logic [5:0] A_LATCH = 6'h18, A_DIR = 6'h17, A_PIN = 6'h16;

  logic       clk = 0, rst_n = 0;
  logic [5:0] bus_addr = A_LATCH;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, pad_in = 0;
  logic       spi_en = 0, spi_master = 0, spi_sck_o = 0, spi_mosi_o = 0, spi_miso_o = 0;
  logic       uart_tx_en = 0, uart_tx_d = 0, uart_rx_en = 0;
  logic [1:0] tmr_oc_en = 0, tmr_oc = 0;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int total = 0, bad = 0;
  string cur = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_ovr u0 (.*);

  // Reference model
  logic [7:0] m_latch, m_dir;
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch <= 0; m_dir <= 0;
      hist = '{8'h00, 8'h00};
    end else begin
      if (bus_wr && bus_addr == A_LATCH) m_latch <= bus_wdata;
      if (bus_wr && bus_addr == A_DIR)   m_dir   <= bus_wdata;
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  function automatic void expect_pads(output logic [7:0] oe, output logic [7:0] o,
                                      output logic [7:0] pu);
    bit slave = spi_en && !spi_master;
    bit mast  = spi_en && spi_master;
    for (int i = 0; i < 8; i++) begin
      bit drv; bit v; bit inp;
      inp = (slave && (i == 7 || i == 5 || i == 4)) || (mast && i == 6) || (uart_rx_en && i == 2);
      v = m_latch[i];
      if (i == 3 && uart_tx_en) begin drv = 1; v = uart_tx_d; end
      else begin
        drv = inp ? 0 : m_dir[i];
        if (i == 7 && mast) v = spi_sck_o;
        if (i == 5 && mast) v = spi_mosi_o;
        if (i == 6 && slave) v = spi_miso_o;
        if (i <= 1 && tmr_oc_en[i]) v = tmr_oc[i];
      end
      if (!rst_n) drv = 0;
      oe[i] = drv;
      o[i]  = drv & v;
      pu[i] = rst_n && !drv && m_latch[i];
    end
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] eoe, eout, epu, erd;
    expect_pads(eoe, eout, epu);
    chk("pad_oe", pad_oe, eoe);
    chk("pad_out", pad_out, eout);
    chk("pad_pu", pad_pu, epu);
    if (!rst_n) erd = (bus_addr == A_PIN) ? 8'h00 : 8'h00;
    else if (bus_addr == A_LATCH) erd = m_latch;
    else if (bus_addr == A_DIR) erd = m_dir;
    else if (bus_addr == A_PIN) erd = hist[1];
    else erd = 0;
    chk("bus_rdata", bus_rdata, erd);
  endtask

  always @(negedge clk) if (!done) compare_all();

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    step();
    bus_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur = "R1"; step(3);
    rst_n = 1; step(2);

    cur = "R2"; wr(A_LATCH, 8'hA5); bus_addr = A_LATCH; step(2);
    cur = "R3"; wr(A_DIR, 8'h3C); bus_addr = A_DIR; step();
    wr(A_PIN, 8'hFF); bus_addr = A_LATCH; step(); bus_addr = A_DIR; step();

    cur = "R4"; wr(A_LATCH, 8'hF0); wr(A_DIR, 8'h33); step(2);
    cur = "R5"; wr(A_DIR, 8'h00); step(); wr(A_LATCH, 8'h0F); step();

    cur = "R6"; bus_addr = A_PIN;
    pad_in = 8'h5A; step(); pad_in = 8'hC3; step(); pad_in = 8'h00; step(3);
    pad_in = 8'hFF; step(4);

    cur = "R7"; wr(A_DIR, 8'hFF); wr(A_LATCH, 8'hB0);
    spi_en = 1; spi_master = 0; step(2);
    wr(A_LATCH, 8'h00); step();
    cur = "R8"; spi_miso_o = 1; step(); spi_miso_o = 0; step();
    wr(A_DIR, 8'hBF); wr(A_LATCH, 8'h40); spi_miso_o = 1; step(2);

    cur = "R9"; spi_master = 1; wr(A_DIR, 8'hFF); wr(A_LATCH, 8'h50);
    spi_sck_o = 1; spi_mosi_o = 0; step(); spi_sck_o = 0; spi_mosi_o = 1; step();
    wr(A_DIR, 8'h10); spi_sck_o = 1; step(2);
    spi_en = 0; spi_master = 0;

    cur = "R10"; wr(A_DIR, 8'h00); uart_tx_en = 1; uart_tx_d = 1; step(); uart_tx_d = 0; step();
    wr(A_LATCH, 8'h08); uart_tx_d = 1; step();
    cur = "R11"; wr(A_DIR, 8'h04); wr(A_LATCH, 8'h04); uart_rx_en = 1; step(2);
    wr(A_LATCH, 8'h00); step();

    cur = "R12"; uart_tx_en = 0; uart_rx_en = 0; wr(A_DIR, 8'h00); wr(A_LATCH, 8'h03);
    tmr_oc_en = 2'b11; tmr_oc = 2'b10; step(2);
    wr(A_DIR, 8'h03); step(); tmr_oc = 2'b01; step(); tmr_oc_en = 2'b01; step();

    cur = "R13"; wr(A_DIR, 8'hC9); wr(A_LATCH, 8'h9A);
    spi_en = 1; uart_tx_en = 1; uart_rx_en = 1; tmr_oc_en = 2'b11; step(2);
    spi_en = 0; uart_tx_en = 0; uart_rx_en = 0; tmr_oc_en = 0; step();
    bus_addr = A_LATCH; step(); chk("latch kept", bus_rdata, 8'h9A);
    bus_addr = A_DIR;   step(); chk("dir kept", bus_rdata, 8'hC9);

    cur = "R1"; rst_n = 0; #1;
    chk("async oe", pad_oe, 8'h00); chk("async pu", pad_pu, 8'h00);
    bus_addr = A_LATCH; #1; chk("async latch", bus_rdata, 8'h00);
    step(2); rst_n = 1; step(2);

    finish_run();
  end
endmodule